// File: doc/BRIEF.md
# Performance Counter Bank Controller

This block counts events for a shared cache. It holds a parameterized number of 32-bit event counters and one 64-bit cycle counter. Each event counter advances by one on every clock in which its event pulse is high, provided its own enable bit and the global enable are both set. The cycle counter advances on every clock in which the cycle-enable input is high, under the same two conditions, with bit 31 of the enable mask as its own enable bit. When a counter wraps, a sticky overflow bit is set. The interrupt output is high while any overflow bit is set whose interrupt-enable bit is also set.

Software reaches the registers through two locations on the host port. A write to the select location (req_sel = 0) stores a 12-bit register address. A data access (req_sel = 1) then writes or reads the register at that address. The host port uses valid/ready. A request is accepted on a clock edge where req_valid and req_ready are both high. A read, of either location, returns its data on rsp_data with rsp_valid one cycle after acceptance. While rsp_valid is high and rsp_ready is low, the response holds and req_ready stays low, so no new request can be accepted. Writes produce no response. The enable, interrupt-enable and overflow registers each have their own set and clear addresses, so software never needs a read-modify-write.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, the enable mask, the interrupt-enable mask and the overflow status are zero, the global enable is off, and irq is low.
- R2: A select write (req_sel=0, req_write=1) stores req_wdata[11:0] as the target address, and a select read returns that address. A data access (req_sel=1) writes or reads the target register. Read data appears on rsp_data with rsp_valid in the cycle after acceptance.
- R3: While rsp_valid=1 and rsp_ready=0, req_ready is 0, and rsp_valid and rsp_data hold their values.
- R4: Control register at 0x400. Bit 0 of a write sets the global enable to that bit's value. Write bit 1 clears all event counters. Write bit 2 clears the cycle counter, so a write of 0x6 clears everything and also turns counting off. A read returns the event-counter count in bits 15:11 and the global enable in bit 0.
- R5: Writing ones to 0x404 sets, and to 0x403 clears, the matching enable bits. Writing ones to 0x406 sets, and to 0x405 clears, the matching interrupt-enable bits. Zero bits leave the register unchanged, and reading either address of a pair returns the register. Event counter n uses bit n, and the cycle counter uses bit 31.
- R6: Event counter n increases by exactly one per clock while its pulse is high, its enable bit is set and the global enable is on. Otherwise it holds.
- R7: Event counter n is read and written at 0x421 + 0x10*n. It wraps from 0xFFFFFFFF to 0, and the wrap sets overflow bit n.
- R8: The cycle counter is 64 bits wide, with its low half at 0x40A and its high half at 0x40B. A carry passes from the low half into the high half, and a wrap of the full 64 bits sets overflow bit 31.
- R9: The overflow status is read at 0x408 (and at 0x407). Writing ones to 0x407 clears those bits, and writing ones to 0x408 sets them. If a counter wraps in the same cycle as a clear of its bit, the bit stays set.
- R10: irq is high exactly when some bit is set in both the overflow status and the interrupt-enable mask.
- R11: Writes to addresses outside the map have no effect, and reads of such addresses return 0. Mask bits for counters that are not implemented cannot be set and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request can be accepted |
| req_sel | input | 1 | 0 selects the address location, 1 selects the data location |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts the read response |
| rsp_data | output | 32 | Read response data |
| evt_pulse | input | NUM_CTR | One event pulse per event counter |
| cyc_en | input | 1 | Cycle-count enable for this clock |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a counter wrapping in the very cycle that a clear write to its overflow bit is accepted. Natural counting would take 2^32 events to reach the wrap. The stimulus therefore preloads the counter to 0xFFFFFFFF and selects the overflow-clear address first. It then drives the clearing data write and a single event pulse on the same clock edge. A 64-bit cycle-counter wrap is reached the same way, by preloading both halves. Random sequences then preload counters close to their limit, so that wraps and sticky overflow bits also occur among mixed enable and interrupt-enable changes.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CYC_BIT = 31;
  localparam int EVT_STRIDE = 16;

  localparam logic [ADDR_W-1:0] A_CTRL     = 12'h400;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 12'h403;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 12'h404;
  localparam logic [ADDR_W-1:0] A_IE_CLR   = 12'h405;
  localparam logic [ADDR_W-1:0] A_IE_SET   = 12'h406;
  localparam logic [ADDR_W-1:0] A_OV_CLR   = 12'h407;
  localparam logic [ADDR_W-1:0] A_OV_SET   = 12'h408;
  localparam logic [ADDR_W-1:0] A_CYC_LO   = 12'h40A;
  localparam logic [ADDR_W-1:0] A_CYC_HI   = 12'h40B;
  localparam logic [ADDR_W-1:0] A_EVT_BASE = 12'h421;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } acc_t;

  function automatic logic [DATA_W-1:0] impl_mask(int n);
    return ((32'h1 << n) - 32'h1) | (32'h1 << CYC_BIT);
  endfunction

  function automatic logic [ADDR_W-1:0] evt_addr(int n);
    return A_EVT_BASE + ADDR_W'(n * EVT_STRIDE);
  endfunction
endpackage

// File: rtl/pcb_host_port.sv
module pcb_host_port
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sel,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] rd_data,
  output acc_t              acc
);
  logic              fire;
  logic [ADDR_W-1:0] sel_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  assign acc.wr    = fire && req_sel && req_write;
  assign acc.rd    = fire && req_sel && !req_write;
  assign acc.addr  = sel_q;
  assign acc.wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (fire && !req_sel && req_write) begin
      sel_q <= req_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req_sel ? rd_data : {{(DATA_W-ADDR_W){1'b0}}, sel_q};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcb_evt_ctr.sv
module pcb_evt_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  // A wrap only counts when the increment actually lands.
  assign ovf = inc && !clr && !wr && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pcb_cyc_ctr.sv
module pcb_cyc_ctr #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic              inc,
  output logic [2*HALF_W-1:0] cnt,
  output logic              ovf
);
  localparam int FULL_W = 2 * HALF_W;

  assign ovf = inc && !clr && !wr_lo && !wr_hi && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr_lo) begin
      cnt[HALF_W-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt[FULL_W-1:HALF_W] <= wdata;
    end else if (inc) begin
      cnt <= cnt + FULL_W'(1);
    end
  end
endmodule

// File: rtl/pcb_ctrl_regs.sv
module pcb_ctrl_regs
  import pcb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ovf_vec,
  output logic              gen,
  output logic [DATA_W-1:0] en,
  output logic [DATA_W-1:0] ie,
  output logic [DATA_W-1:0] ovs,
  output logic              clr_evt,
  output logic              clr_cyc,
  output logic              irq
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_CTR);

  logic              ctrl_wr;
  logic [DATA_W-1:0] en_n, ie_n, ovs_n;

  assign ctrl_wr = wr && (addr == A_CTRL);
  assign clr_evt = ctrl_wr && wdata[1];
  assign clr_cyc = ctrl_wr && wdata[2];

  always_comb begin
    en_n  = en;
    ie_n  = ie;
    ovs_n = ovs;
    if (wr) begin
      unique case (addr)
        A_EN_SET: en_n  = en | (wdata & MASK);
        A_EN_CLR: en_n  = en & ~wdata;
        A_IE_SET: ie_n  = ie | (wdata & MASK);
        A_IE_CLR: ie_n  = ie & ~wdata;
        A_OV_SET: ovs_n = ovs | (wdata & MASK);
        A_OV_CLR: ovs_n = ovs & ~wdata;
        default: ;
      endcase
    end
    // A wrap in the same cycle as a clear keeps the bit set.
    ovs_n = ovs_n | (ovf_vec & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen <= 1'b0;
      en  <= '0;
      ie  <= '0;
      ovs <= '0;
    end else begin
      if (ctrl_wr) gen <= wdata[0];
      en  <= en_n;
      ie  <= ie_n;
      ovs <= ovs_n;
    end
  end

  assign irq = |(ovs & ie);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_sel,
  input  logic               req_write,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_data,
  input  logic [NUM_CTR-1:0] evt_pulse,
  input  logic               cyc_en,
  output logic               irq
);
  localparam int HALF_W = DATA_W;

  acc_t               acc;
  logic [DATA_W-1:0]  rd_data;
  logic               gen, clr_evt, clr_cyc;
  logic [DATA_W-1:0]  en, ie, ovs, ovf_vec;
  logic [DATA_W-1:0]  ctr_q   [NUM_CTR];
  logic [NUM_CTR-1:0] evt_ovf;
  logic [2*HALF_W-1:0] cyc_q;
  logic               cyc_ovf;

  // Flat views of internal signals for the bound checker.
  logic               acc_wr, acc_rd;
  logic [ADDR_W-1:0]  acc_addr;
  logic [DATA_W-1:0]  cnt0_w;
  logic               evt0_w;
  assign acc_wr   = acc.wr;
  assign acc_rd   = acc.rd;
  assign acc_addr = acc.addr;
  assign cnt0_w   = ctr_q[0];
  assign evt0_w   = evt_pulse[0];

  pcb_host_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_sel   (req_sel),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rd_data   (rd_data),
    .acc       (acc)
  );

  pcb_ctrl_regs #(.NUM_CTR(NUM_CTR)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (acc.wr),
    .addr    (acc.addr),
    .wdata   (acc.wdata),
    .ovf_vec (ovf_vec),
    .gen     (gen),
    .en      (en),
    .ie      (ie),
    .ovs     (ovs),
    .clr_evt (clr_evt),
    .clr_cyc (clr_cyc),
    .irq     (irq)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_evt
    pcb_evt_ctr #(.W(DATA_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_evt),
      .wr    (acc.wr && (acc.addr == evt_addr(i))),
      .wdata (acc.wdata),
      .inc   (evt_pulse[i] && en[i] && gen),
      .cnt   (ctr_q[i]),
      .ovf   (evt_ovf[i])
    );
  end

  pcb_cyc_ctr #(.HALF_W(HALF_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_cyc),
    .wr_lo (acc.wr && (acc.addr == A_CYC_LO)),
    .wr_hi (acc.wr && (acc.addr == A_CYC_HI)),
    .wdata (acc.wdata),
    .inc   (cyc_en && en[CYC_BIT] && gen),
    .cnt   (cyc_q),
    .ovf   (cyc_ovf)
  );

  always_comb begin
    ovf_vec = '0;
    for (int i = 0; i < NUM_CTR; i++) ovf_vec[i] = evt_ovf[i];
    ovf_vec[CYC_BIT] = cyc_ovf;
  end

  always_comb begin
    rd_data = '0;
    unique case (acc.addr)
      A_CTRL:             rd_data = (DATA_W'(NUM_CTR) << 11) | DATA_W'(gen);
      A_EN_CLR, A_EN_SET: rd_data = en;
      A_IE_CLR, A_IE_SET: rd_data = ie;
      A_OV_CLR, A_OV_SET: rd_data = ovs;
      A_CYC_LO:           rd_data = cyc_q[HALF_W-1:0];
      A_CYC_HI:           rd_data = cyc_q[2*HALF_W-1:HALF_W];
      default: begin
        for (int i = 0; i < NUM_CTR; i++)
          if (acc.addr == evt_addr(i)) rd_data = ctr_q[i];
      end
    endcase
  end
endmodule

// File: rtl/perf_counter_bank_sva.sv
module perf_counter_bank_sva
  import pcb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_data,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              gen,
  input logic [31:0]       en,
  input logic [31:0]       ie,
  input logic [31:0]       ovs,
  input logic              evt0,
  input logic [31:0]       cnt0,
  input logic              irq
);
  // R2: an accepted data read yields a response next cycle
  a_r2_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);

  // R3: a stalled response blocks new requests
  a_r3_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R3: a stalled response holds its data
  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R6: an enabled pulse advances counter 0 by one
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && en[0] && evt0 && !acc_wr) |=> (cnt0 == $past(cnt0) + 32'd1));

  // R6: without a qualified pulse or a write, counter 0 holds
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(gen && en[0] && evt0) && !acc_wr) |=> $stable(cnt0));

  // R7: a wrap of counter 0 sets its overflow bit
  a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && en[0] && evt0 && (&cnt0) && !acc_wr) |=> ovs[0]);

  // R9: overflow bits only fall through a clear write
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && acc_addr == A_OV_CLR) |=> ((ovs & $past(ovs)) == $past(ovs)));

  // R10: no interrupt without both a status bit and an enable bit
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0 || ovs == '0) |-> !irq);
endmodule

bind perf_counter_bank perf_counter_bank_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .acc_wr    (acc_wr),
  .acc_rd    (acc_rd),
  .acc_addr  (acc_addr),
  .gen       (gen),
  .en        (en),
  .ie        (ie),
  .ovs       (ovs),
  .evt0      (evt0_w),
  .cnt0      (cnt0_w),
  .irq       (irq)
);

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
  localparam int NUM = 4;
  localparam logic [31:0] M = ((32'h1 << NUM) - 1) | 32'h8000_0000;
  localparam logic [11:0] CTRL = 12'h400, EN_CLR = 12'h403, EN_SET = 12'h404,
    IE_CLR = 12'h405, IE_SET = 12'h406, OV_CLR = 12'h407, OV_SET = 12'h408,
    CYC_LO = 12'h40A, CYC_HI = 12'h40B;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_sel = 0, req_write = 0, rsp_ready = 1, cyc_en = 0;
  logic [31:0] req_wdata = 0;
  logic [NUM-1:0] evt_pulse = 0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_data;

  int n_cmp = 0, n_err = 0;
  bit done = 0;
  logic [31:0] m_cnt [NUM];
  logic [63:0] m_cyc;
  logic [31:0] m_en, m_ie, m_ovs;
  logic m_gen;
  logic [31:0] last_rsp;

  always #10 clk = ~clk;

  perf_counter_bank #(.NUM_CTR(NUM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .evt_pulse(evt_pulse), .cyc_en(cyc_en), .irq(irq));

  function automatic logic [11:0] caddr(int n);
    return 12'h421 + 12'(n * 16);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One host transfer; inputs change only at negedges.
  task automatic xfer(input logic sel, input logic wr, input logic [31:0] d,
                      input logic [NUM-1:0] ev, input logic ce);
    @(negedge clk);
    req_valid = 1; req_sel = sel; req_write = wr; req_wdata = d;
    evt_pulse = ev; cyc_en = ce;
    @(negedge clk);
    req_valid = 0; evt_pulse = 0; cyc_en = 0;
    if (!wr) begin
      chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
      last_rsp = rsp_data;
    end
  endtask

  // Model of one counting cycle.
  function automatic void step(input logic [NUM-1:0] ev, input logic ce);
    for (int i = 0; i < NUM; i++)
      if (ev[i] && m_en[i] && m_gen) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) m_ovs[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 1;
      end
    if (ce && m_en[31] && m_gen) begin
      if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) m_ovs[31] = 1'b1;
      m_cyc = m_cyc + 1;
    end
  endfunction

  // Register write with model update.
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    xfer(0, 1, {20'h0, a}, '0, 0);
    xfer(1, 1, d, '0, 0);
    case (a)
      CTRL: begin
        m_gen = d[0];
        if (d[1]) for (int i = 0; i < NUM; i++) m_cnt[i] = 0;
        if (d[2]) m_cyc = 0;
      end
      EN_SET: m_en = m_en | (d & M);
      EN_CLR: m_en = m_en & ~d;
      IE_SET: m_ie = m_ie | (d & M);
      IE_CLR: m_ie = m_ie & ~d;
      OV_SET: m_ovs = m_ovs | (d & M);
      OV_CLR: m_ovs = m_ovs & ~d;
      CYC_LO: m_cyc[31:0] = d;
      CYC_HI: m_cyc[63:32] = d;
      default:
        for (int i = 0; i < NUM; i++) if (a == caddr(i)) m_cnt[i] = d;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    xfer(0, 1, {20'h0, a}, '0, 0);
    xfer(1, 0, 0, '0, 0);
    chk(req, 64'(last_rsp), 64'(exp));
  endtask

  task automatic burst(input logic [NUM-1:0] ev, input logic ce, input int n);
    @(negedge clk);
    evt_pulse = ev; cyc_en = ce;
    repeat (n) @(negedge clk);
    evt_pulse = 0; cyc_en = 0;
    for (int k = 0; k < n; k++) step(ev, ce);
  endtask

  task automatic chk_irq(input string req);
    chk(req, 64'(irq), 64'(|(m_ovs & m_ie)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd4321));
    for (int i = 0; i < NUM; i++) m_cnt[i] = 0;
    m_cyc = 0; m_en = 0; m_ie = 0; m_ovs = 0; m_gen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, R4 counter-count field
    chk("R1 irq", 64'(irq), 64'd0);
    rd_chk("R4 ctrl read", CTRL, 32'(NUM) << 11);
    rd_chk("R1 enable", EN_SET, 0);
    rd_chk("R1 overflow", OV_SET, 0);
    rd_chk("R1 counter", caddr(NUM-1), 0);
    rd_chk("R1 cycle", CYC_HI, 0);

    // R2 select readback
    xfer(0, 1, 32'h0000_0123, '0, 0);
    xfer(0, 0, 0, '0, 0);
    chk("R2 select read", 64'(last_rsp), 64'h123);

    // R11 unimplemented bits and addresses
    wr_reg(EN_SET, 32'hFFFF_FFFF);
    rd_chk("R11 enable mask", EN_CLR, M);
    wr_reg(EN_CLR, 32'hFFFF_FFFF);
    rd_chk("R5 enable cleared", EN_SET, 0);
    wr_reg(caddr(NUM), 32'hDEAD_BEEF);
    rd_chk("R11 unmapped counter", caddr(NUM), 0);
    wr_reg(12'h401, 32'h5A5A_5A5A);
    rd_chk("R11 unmapped reg", 12'h401, 0);
    rd_chk("R11 no side effect", caddr(0), 0);

    // R6 global enable and per-counter enable gating
    wr_reg(EN_SET, 32'h1);
    burst(4'b0011, 0, 5);
    rd_chk("R6 global off holds", caddr(0), 0);
    wr_reg(CTRL, 32'h1);
    burst(4'b0011, 0, 5);
    rd_chk("R6 counts", caddr(0), 5);
    rd_chk("R6 disabled holds", caddr(1), 0);
    rd_chk("R4 ctrl gen bit", CTRL, (32'(NUM) << 11) | 1);

    // R7 wrap sets overflow, R10 interrupt
    wr_reg(caddr(2), 32'hFFFF_FFFE);
    wr_reg(EN_SET, 32'h4);
    wr_reg(IE_SET, 32'h4);
    chk_irq("R10 before wrap");
    burst(4'b0100, 0, 3);
    rd_chk("R7 wrapped value", caddr(2), 1);
    rd_chk("R7 overflow bit", OV_SET, m_ovs);
    chk("R10 irq after wrap", 64'(irq), 64'd1);
    wr_reg(IE_CLR, 32'h4);
    chk("R10 irq masked", 64'(irq), 64'd0);

    // R8 cycle counter carry and 64-bit wrap
    wr_reg(CYC_LO, 32'hFFFF_FFFE);
    wr_reg(EN_SET, 32'h8000_0000);
    burst('0, 1, 3);
    rd_chk("R8 cycle low", CYC_LO, 1);
    rd_chk("R8 cycle carry", CYC_HI, 1);
    wr_reg(CYC_LO, 32'hFFFF_FFFF);
    wr_reg(CYC_HI, 32'hFFFF_FFFF);
    wr_reg(IE_SET, 32'h8000_0000);
    burst('0, 1, 1);
    rd_chk("R8 cycle wrap low", CYC_LO, 0);
    rd_chk("R8 overflow bit 31", OV_CLR, m_ovs);
    chk("R10 irq cycle", 64'(irq), 64'd1);

    // R9 clear, set, and wrap colliding with a clear
    wr_reg(OV_CLR, 32'hFFFF_FFFF);
    rd_chk("R9 cleared", OV_SET, 0);
    wr_reg(OV_SET, 32'h2);
    rd_chk("R9 set write", OV_SET, 32'h2);
    wr_reg(OV_CLR, 32'h2);
    wr_reg(caddr(0), 32'hFFFF_FFFF);
    xfer(0, 1, {20'h0, OV_CLR}, '0, 0);
    xfer(1, 1, 32'h1, 4'b0001, 0);
    m_cnt[0] = 0; m_ovs[0] = 1'b1;
    rd_chk("R9 wrap beats clear", OV_SET, 32'h1);
    rd_chk("R7 collision count", caddr(0), 0);

    // R4 reset of all counters with 0x6
    burst(4'b0001, 1, 4);
    wr_reg(CTRL, 32'h6);
    rd_chk("R4 event cleared", caddr(0), 0);
    rd_chk("R4 cycle cleared", CYC_LO, 0);
    rd_chk("R4 counting off", CTRL, 32'(NUM) << 11);
    wr_reg(CTRL, 32'h1);

    // R3 back-pressure on the response
    xfer(0, 1, {20'h0, CTRL}, '0, 0);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_sel = 1; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    hold = rsp_data;
    chk("R3 valid", 64'(rsp_valid), 64'd1);
    chk("R3 ready low", 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk("R3 still valid", 64'(rsp_valid), 64'd1);
    chk("R3 data held", 64'(rsp_data), 64'(hold));
    rsp_ready = 1;
    @(negedge clk);
    chk("R3 released", 64'(rsp_valid), 64'd0);

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      logic [31:0] r;
      int idx;
      op = $urandom_range(0, 7);
      r = $urandom;
      idx = $urandom_range(0, NUM-1);
      case (op)
        0: wr_reg(EN_SET, r);
        1: wr_reg(EN_CLR, r);
        2: wr_reg(r[0] ? IE_SET : IE_CLR, $urandom);
        3: burst(NUM'(r), r[31], $urandom_range(1, 20));
        4: wr_reg(caddr(idx), 32'hFFFF_FFFF - 32'($urandom_range(0, 10)));
        5: begin
          rd_chk("R7 random counter", caddr(idx), m_cnt[idx]);
          rd_chk("R9 random overflow", OV_SET, m_ovs);
          chk_irq("R10 random irq");
        end
        6: wr_reg(OV_CLR, r);
        default: wr_reg(CTRL, {31'h0, (r[3:0] != 0)});
      endcase
    end
    for (int i = 0; i < NUM; i++) rd_chk("R6 final counter", caddr(i), m_cnt[i]);
    rd_chk("R8 final cycle low", CYC_LO, m_cyc[31:0]);
    rd_chk("R8 final cycle high", CYC_HI, m_cyc[63:32]);
    rd_chk("R5 final enable", EN_SET, m_en);
    rd_chk("R5 final irq enable", IE_SET, m_ie);
    rd_chk("R9 final overflow", OV_SET, m_ovs);
    chk_irq("R10 final irq");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule